// File: doc/BRIEF.md
# Recursive Vertical-Crosswise Multiply-Accumulate Unit

This block multiplies two 32-bit unsigned operands and adds the 64-bit product into a running 72-bit accumulator register. The 8 bits above the product width are guard bits. They let a long run of large products build up before the sum rolls over. The multiplier is built by recursion in quadrants. An 8×8 leaf forms its result column by column: each column adds the bitwise ANDs of the operand bit pairs whose indices sum to that column, plus the carry passed up from the column below. Each wider level, first 16×16 and then 32×32, splits both operands into halves. It forms the four half-by-half products with the level below, then merges them with parallel-prefix adders of the Kogge-Stone type. One more prefix adder adds the product to the accumulator.

The enable input is the only qualifier on the operand stream, and it acts as a valid strobe that cannot be refused. There is no ready and no back-pressure: the unit takes one operand pair in every cycle in which the enable is high. A synchronous clear empties the accumulator. The accumulator is registered, so the effect of a cycle's inputs appears on the output after the next rising clock edge.

Top module: `vcm_mac`

## Requirements
- R1: For every pair of 32-bit unsigned operands, including 0, all-ones and single set bits, the product added to the accumulator equals the exact 64-bit value a×b.
- R2: With clr low and en high at a rising edge, the accumulator takes the value acc + a×b after that edge.
- R3: With clr low and en low at a rising edge, the accumulator keeps its value, whatever the operands are.
- R4: With clr high at a rising edge, the accumulator reads zero after that edge.
- R5: When clr and en are both high at an edge, the clear takes effect and the operands are discarded, so the accumulator reads zero.
- R6: The accumulator is 72 bits wide and wraps modulo 2^72. A carry out of bit 71 is dropped, and the wrapped value is smaller than the value before the add.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear of the accumulator, has priority over en |
| en | input | 1 | Operand strobe; when high, a×b is accumulated at this edge |
| a | input | 32 | Unsigned multiplicand |
| b | input | 32 | Unsigned multiplier |
| acc | output | 72 | Registered accumulator value |

## Verification
Corner operand pairs are each accumulated alone after a clear, so that the accumulator shows a single product. The pairs are zero against anything, all-ones squared, the top bit squared and walking single bits. They separate a wrong column carry in the leaf from a misplaced quadrant shift at the 16-bit or 32-bit level. Random operand runs with en toggling separate a correct running sum from a hold that leaks the operands. Cycles with clr and en both high show which of the two wins. A long run of all-ones products drives the sum past bit 71 and shows whether the guard bits wrap or saturate.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
  // Width at which the quadrant recursion stops and the column leaf is used.
  localparam int unsigned LEAF_W = 8;

  // Width needed for a column tally in a w-by-w column multiplier.
  function automatic int unsigned tally_width(input int unsigned w);
    return $clog2(2 * w) + 1;
  endfunction
endpackage

// File: rtl/vcm_prefix_adder.sv
module vcm_prefix_adder #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s,
  output logic         cout
);
  localparam int unsigned STAGES = $clog2(W);

  logic [W-1:0] gen  [0:STAGES];
  logic [W-1:0] prop [0:STAGES-1];

  assign gen[0]  = x & y;
  assign prop[0] = x ^ y;

  for (genvar st = 0; st < STAGES; st++) begin : g_stage
    localparam int unsigned D = 1 << st;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= D) begin : g_merge
        assign gen[st+1][i] = gen[st][i] | (prop[st][i] & gen[st][i-D]);
        if (st < STAGES - 1) begin : g_pmerge
          assign prop[st+1][i] = prop[st][i] & prop[st][i-D];
        end
      end else begin : g_pass
        assign gen[st+1][i] = gen[st][i];
        if (st < STAGES - 1) begin : g_ppass
          assign prop[st+1][i] = prop[st][i];
        end
      end
    end
  end

  assign s    = prop[0] ^ {gen[STAGES][W-2:0], 1'b0};
  assign cout = gen[STAGES][W-1];
endmodule

// File: rtl/vcm_leaf.sv
module vcm_leaf
  import vcm_pkg::*;
#(
  parameter int unsigned W = LEAF_W
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  localparam int unsigned CW = tally_width(W);

  logic [CW-1:0] carry;
  logic [CW-1:0] tally;

  // Column k gathers every a[i]&b[k-i] plus the carry from column k-1.
  always_comb begin
    p     = '0;
    carry = '0;
    tally = '0;
    for (int k = 0; k < 2 * int'(W) - 1; k++) begin
      tally = carry;
      for (int i = 0; i < int'(W); i++) begin
        if ((k - i) >= 0 && (k - i) < int'(W)) begin
          tally = tally + CW'(a[i] & b[k-i]);
        end
      end
      p[k]  = tally[0];
      carry = tally >> 1;
    end
    p[2*W-1] = carry[0];
  end
endmodule

// File: rtl/vcm_quad.sv
module vcm_quad
  import vcm_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  if (W <= LEAF_W) begin : g_leaf
    vcm_leaf #(.W(W)) leaf_i (.a(a), .b(b), .p(p));
  end else begin : g_split
    localparam int unsigned H = W / 2;

    logic [W-1:0]   p_ll, p_lh, p_hl, p_hh;
    logic [W:0]     mid_sum;
    logic           mid_co;
    logic [2*W-1:0] mid_shift;
    logic           fin_co;

    vcm_quad #(.W(H)) q_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(p_ll));
    vcm_quad #(.W(H)) q_lh (.a(a[H-1:0]), .b(b[W-1:H]), .p(p_lh));
    vcm_quad #(.W(H)) q_hl (.a(a[W-1:H]), .b(b[H-1:0]), .p(p_hl));
    vcm_quad #(.W(H)) q_hh (.a(a[W-1:H]), .b(b[W-1:H]), .p(p_hh));

    // Cross terms summed one bit wider so their carry is kept.
    vcm_prefix_adder #(.W(W + 1)) add_mid (
      .x({1'b0, p_lh}), .y({1'b0, p_hl}), .s(mid_sum), .cout(mid_co)
    );

    assign mid_shift = (2 * W)'(mid_sum) << H;

    // Low and high quadrants do not overlap, so they are simply concatenated.
    vcm_prefix_adder #(.W(2 * W)) add_fin (
      .x({p_hh, p_ll}), .y(mid_shift), .s(p), .cout(fin_co)
    );

    always_comb begin
      if (!$isunknown({a, b})) begin
        assert_no_carry_out_R1: assert (mid_co == 1'b0 && fin_co == 1'b0)
          else $error("quadrant merge overflowed its width");
      end
    end
  end
endmodule

// File: rtl/vcm_mac.sv
module vcm_mac
  import vcm_pkg::*;
#(
  parameter  int unsigned OP_W    = 32,
  parameter  int unsigned GUARD_W = 8,
  localparam int unsigned PROD_W  = 2 * OP_W,
  localparam int unsigned ACC_W   = PROD_W + GUARD_W
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             en,
  input  logic [OP_W-1:0]  a,
  input  logic [OP_W-1:0]  b,
  output logic [ACC_W-1:0] acc
);
  logic [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W-1:0]  acc_sum;
  logic              acc_co;

  vcm_quad #(.W(OP_W)) mul_i (.a(a), .b(b), .p(prod));

  vcm_prefix_adder #(.W(ACC_W)) add_acc (
    .x(acc_q), .y(ACC_W'(prod)), .s(acc_sum), .cout(acc_co)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      acc_q <= '0;
    end else if (en) begin
      acc_q <= acc_sum;
    end
  end

  assign acc = acc_q;

  assert_product_exact_R1: assert property (@(posedge clk) disable iff (clr)
    en |-> prod == PROD_W'(PROD_W'(a) * PROD_W'(b)))
    else $error("product mismatch");

  assert_accumulate_R2: assert property (@(posedge clk) disable iff (clr)
    en |=> acc == $past(acc) + ACC_W'($past(prod)))
    else $error("accumulate mismatch");

  assert_hold_R3: assert property (@(posedge clk) disable iff (clr)
    !en |=> $stable(acc))
    else $error("accumulator moved while idle");

  assert_clear_zero_R4: assert property (@(posedge clk)
    clr |=> acc == '0)
    else $error("clear did not empty accumulator");

  assert_clear_wins_R5: assert property (@(posedge clk)
    (clr && en) |=> acc == '0)
    else $error("enable overrode clear");

  assert_wrap_drop_R6: assert property (@(posedge clk) disable iff (clr)
    (en && acc_co) |=> acc < $past(acc))
    else $error("wrap did not drop the carry");
endmodule

// File: tb/vcm_mac_tb_top.sv
`timescale 1ns/1ps
module vcm_mac_tb_top;
  localparam int unsigned ACC_W = 72;

  typedef struct {
    logic [ACC_W-1:0] exp;
    string            tag;
  } item_t;

  logic             clk = 1'b0;
  logic             clr = 1'b1;
  logic             en  = 1'b0;
  logic [31:0]      a   = '0;
  logic [31:0]      b   = '0;
  logic [ACC_W-1:0] acc;

  int checks   = 0;
  int failures = 0;
  logic [ACC_W-1:0] model = '0;
  item_t sb_q[$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  vcm_mac dut_i (.clk(clk), .clr(clr), .en(en), .a(a), .b(b), .acc(acc));

  // Driver: drive at the falling edge, push the value expected after the next rise.
  task automatic drive(input logic c, input logic e, input logic [31:0] x,
                       input logic [31:0] y, input string tag);
    item_t it;
    @(negedge clk);
    clr = c; en = e; a = x; b = y;
    if (c) model = '0;
    else if (e) model = model + ACC_W'(64'(x) * 64'(y));
    it.exp = model;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic single(input logic [31:0] x, input logic [31:0] y);
    drive(1'b1, 1'b0, 32'h0, 32'h0, "R4");
    drive(1'b0, 1'b1, x, y, "R1");
  endtask

  // Monitor: compare two ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (acc !== it.exp) begin
          failures++;
          $display("FAIL %s acc=%h expected=%h", it.tag, acc, it.exp);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // Reset state (R4)
    drive(1'b1, 1'b0, 32'h0, 32'h0, "R4");
    drive(1'b1, 1'b0, 32'hffffffff, 32'hffffffff, "R4");

    // Corner products, each alone (R1)
    single(32'h0, 32'hdeadbeef);
    single(32'h12345678, 32'h0);
    single(32'hffffffff, 32'hffffffff);
    single(32'h80000000, 32'h80000000);
    single(32'h1, 32'hffffffff);
    single(32'hffffffff, 32'h00010000);
    single(32'h0000ff00, 32'h00ff0000);
    for (int s = 0; s < 32; s++) single(32'h1 << s, 32'h1 << (31 - s));
    for (int s = 0; s < 24; s++) single($urandom(), $urandom());

    // Running sums with idle cycles (R2, R3)
    drive(1'b1, 1'b0, 32'h0, 32'h0, "R4");
    for (int n = 0; n < 120; n++) begin
      if ((n % 3) == 2) drive(1'b0, 1'b0, $urandom(), $urandom(), "R3");
      else drive(1'b0, 1'b1, $urandom(), $urandom(), "R2");
    end
    drive(1'b0, 1'b0, 32'hffffffff, 32'hffffffff, "R3");
    drive(1'b0, 1'b0, 32'hffffffff, 32'hffffffff, "R3");

    // Clear and enable together (R5)
    drive(1'b1, 1'b1, 32'hffffffff, 32'hffffffff, "R5");
    drive(1'b0, 1'b1, 32'h3, 32'h5, "R2");
    drive(1'b1, 1'b1, 32'h7, 32'h9, "R5");

    // Long all-ones run wraps past bit 71 (R6)
    drive(1'b1, 1'b0, 32'h0, 32'h0, "R4");
    for (int n = 0; n < 300; n++) drive(1'b0, 1'b1, 32'hffffffff, 32'hffffffff, "R6");
    drive(1'b0, 1'b0, 32'h0, 32'h0, "R6");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL R2 pending=%0d expected=0", sb_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule